// File: doc/BRIEF.md
# Serial Frame Serializer Master

This block is the transmit side of a clocked serial master link. It sends frames of 4 to 32 bits, most significant bit first, on a serial data line. It also drives the serial clock and an active-low chip select, since it always acts as the bus master. The bits of a frame come from one of two places. One is a data word written by software. The other is the state of a 32-bit parallel input bus, captured in the cycle the frame starts.

Software uses a small write port to set the frame length, the data source, the clock polarity, the clock rate, and two behaviour controls. The first control lets the serial clock run all the time instead of only during frames. The second is a continuation control: it keeps chip select asserted from one frame to the next. If continuation is on and no new frame is waiting, chip select stays asserted and the data line is held high. When the free-running clock is also on, the clock keeps toggling in this state.

Each write to the trigger address requests one frame, and one request can wait while a frame is in progress. A one-cycle done pulse marks the end of every frame.

Top module: `ser_master`

## Requirements
- R1: Config bits [4:0] hold the frame length minus one. The frame carries that many plus one bits, up to 32. Any value below 3 is treated as 3, which gives a 4-bit frame. Bits go out most significant first, taken from the low bits of the source word.
- R2: Config bit 5 selects the data source. 0 selects the word written at address 0. 1 selects the parallel input bus, sampled in the cycle the frame starts. Later changes to the bus do not alter that frame.
- R3: The data line changes on the leading clock edge, so it is stable when the trailing edge arrives (the edge that returns the clock to its idle level). Whenever chip select is inactive, and while it is held with no frame being shifted, the data line is 1.
- R4: Config bit 8 sets the clock polarity: the clock idles at the value of this bit.
- R5: Config bit 6 set makes the serial clock toggle continuously, including while chip select is inactive. With the bit clear, the clock does not move while chip select is inactive.
- R6: Config bit 7 (continuation) keeps chip select asserted between back-to-back frames. With nothing pending, chip select stays asserted and the data line stays 1 until a new request arrives or the bit is cleared.
- R7: With continuation clear, chip select is inactive for at least one full serial clock period, 2 x half-period system cycles, between two frames.
- R8: Config bits [15:9] give the serial clock half period in system clock cycles. A value of 0 acts as 1.
- R9: frame_done is a single-cycle pulse that follows the last trailing edge of a frame. Chip select was asserted in the cycle before the pulse.
- R10: After reset, chip select is inactive, the data line is 1, the clock is 0 and frame_done is 0. The configuration then gives 32-bit frames, a half period of 1, the software source, a gated clock, continuation off and clock polarity 0.
- R11: A write to address 2 requests one frame. A request made while a frame is shifting is held and sent after it, so two triggers give two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data word, 1 configuration, 2 frame trigger |
| wr_data | input | 32 | Write data |
| par_in | input | 32 | Parallel input bus, sampled at frame start when selected |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | 1 | Serial data out |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The assertions rely on two things. The polarity and clock-mode fields are not rewritten while chip select is asserted. Clearing the continuation bit during a hold is the one reconfiguration that may happen with chip select asserted. Under these conditions, a trailing clock edge seen while chip select is asserted belongs to a frame or to a hold, and a gated clock cannot move between frames. The stimulus writes the configuration only when the link is idle, or during a hold to end it. It only requests a second frame while the first is already shifting.

// File: rtl/ser_master.sv
module ser_master #(
  parameter int DW     = 32,
  parameter int DIVW   = 7,
  parameter int MINLEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] par_in,
  output logic          sck,
  output logic          cs_n,
  output logic          sdo,
  output logic          frame_done
);
  localparam int LW     = $clog2(DW);
  localparam int B_SRC  = LW;
  localparam int B_FREE = LW + 1;
  localparam int B_KEEP = LW + 2;
  localparam int B_CPOL = LW + 3;
  localparam int B_DIV  = LW + 4;
  localparam logic [1:0] A_ALT = 2'd0;
  localparam logic [1:0] A_CFG = 2'd1;
  localparam logic [1:0] A_GO  = 2'd2;
  localparam logic [LW-1:0] LEN_FLOOR = LW'(MINLEN - 1);
  localparam logic [LW-1:0] LEN_TOP   = LW'(DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD, S_GAP} st_t;

  st_t             st;
  logic [DW-1:0]   alt_q, sh_q;
  logic [LW-1:0]   len_q, bits_q;
  logic [DIVW-1:0] half_q, hc_q;
  logic            src_q, free_q, keep_q, cpol_q;
  logic            pend_q, ph_q, gap_q, sdo_q, done_q;

  wire cfg_wr = wr_en && (wr_addr == A_CFG);
  wire go_wr  = wr_en && (wr_addr == A_GO);

  wire [DIVW-1:0] half_eff = (half_q == '0) ? DIVW'(1) : half_q;
  wire            tick     = hc_q >= (half_eff - DIVW'(1));
  wire            toggle   = free_q || (st == S_RUN);
  wire [LW-1:0]   len_eff  = (len_q < LEN_FLOOR) ? LEN_FLOOR : len_q;
  wire [DW-1:0]   src_word = src_q ? par_in : alt_q;
  wire            waiting  = (st == S_IDLE) || (st == S_HOLD);
  wire            launch   = tick && waiting && pend_q && !(ph_q ^ toggle);
  wire            last     = tick && (st == S_RUN) && ph_q && (bits_q == '0);
  wire            relaunch = last && keep_q && pend_q;
  wire            load     = launch || relaunch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= '0;
      len_q  <= LEN_TOP;
      src_q  <= 1'b0;
      free_q <= 1'b0;
      keep_q <= 1'b0;
      cpol_q <= 1'b0;
      half_q <= DIVW'(1);
    end else begin
      if (wr_en && wr_addr == A_ALT) alt_q <= wr_data;
      if (cfg_wr) begin
        len_q  <= wr_data[LW-1:0];
        src_q  <= wr_data[B_SRC];
        free_q <= wr_data[B_FREE];
        keep_q <= wr_data[B_KEEP];
        cpol_q <= wr_data[B_CPOL];
        half_q <= wr_data[B_DIV +: DIVW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      ph_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hc_q   <= tick ? '0 : hc_q + DIVW'(1);
      pend_q <= (pend_q && !load) || go_wr;
      if (cfg_wr && st != S_RUN) ph_q <= 1'b0;
      else if (tick && toggle)   ph_q <= !ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh_q   <= '0;
      bits_q <= '0;
      sdo_q  <= 1'b1;
      done_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        sh_q   <= src_word << (LEN_TOP - len_eff);
        bits_q <= len_eff;
        st     <= S_RUN;
      end else if (tick) begin
        case (st)
          S_RUN: begin
            if (!ph_q) begin
              sdo_q <= sh_q[DW-1];
              sh_q  <= {sh_q[DW-2:0], 1'b0};
            end else if (bits_q == '0) begin
              sdo_q <= 1'b1;
              gap_q <= 1'b0;
              st    <= keep_q ? S_HOLD : S_GAP;
            end else begin
              bits_q <= bits_q - LW'(1);
            end
          end
          S_HOLD: begin
            gap_q <= 1'b0;
            if (!keep_q) st <= S_GAP;
          end
          S_GAP: begin
            gap_q <= 1'b1;
            if (gap_q) st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sck        = ph_q ^ cpol_q;
  assign cs_n       = !((st == S_RUN) || (st == S_HOLD));
  assign sdo        = sdo_q;
  assign frame_done = done_q;
endmodule

// File: rtl/ser_master_chk.sv
module ser_master_chk #(
  parameter int MINLEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic sdo,
  input logic frame_done,
  input logic free_q,
  input logic cpol_q
);
  logic       sck_d, csn_d;
  logic [7:0] cnt;

  wire trail = !csn_d && (sck == cpol_q) && (sck_d != cpol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
      cnt   <= '0;
    end else begin
      sck_d <= sck;
      csn_d <= cs_n;
      if (frame_done || (cs_n && csn_d)) cnt <= '0;
      else if (trail && cnt != 8'hFF)    cnt <= cnt + 8'd1;
    end
  end

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sdo);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_after_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(!cs_n));

  assert_gated_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_q && cs_n && $past(cs_n) && $stable(free_q) && $stable(cpol_q)) |-> $stable(sck));

  assert_min_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (({1'b0, cnt} + 9'(trail)) >= 9'(MINLEN)));
endmodule

bind ser_master ser_master_chk #(.MINLEN(MINLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdo(sdo),
  .frame_done(frame_done), .free_q(free_q), .cpol_q(cpol_q)
);

// File: tb/ser_master_bench.sv
`timescale 1ns/100ps
module ser_master_bench;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0, par_in = '0;
  logic        sck, cs_n, sdo, frame_done;

  ser_master u_ser_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .par_in(par_in), .sck(sck), .cs_n(cs_n), .sdo(sdo), .frame_done(frame_done)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: trailing edges capture data, frame_done closes a frame
  logic        mon_cpol = 1'b0;
  logic        p_sck = 1'b0, p_csn = 1'b1, p_sdo = 1'b1, p_done = 1'b0;
  logic [63:0] cap = '0, last_word = '0;
  int          nb = 0, last_n = 0, frames = 0, dbl_done = 0, done_unsel = 0;

  always @(negedge clk) begin
    if (!p_csn && p_sck != mon_cpol && sck == mon_cpol) begin
      cap = {cap[62:0], p_sdo};
      nb++;
    end
    if (frame_done) begin
      if (p_done) dbl_done++;
      if (p_csn) done_unsel++;
      last_word = cap;
      last_n = nb;
      frames++;
      cap = '0;
      nb = 0;
    end else if (cs_n && p_csn) begin
      cap = '0;
      nb = 0;
    end
    p_sck = sck; p_csn = cs_n; p_sdo = sdo; p_done = frame_done;
  end

  function automatic logic [31:0] mk(int lm1, bit src, bit fr, bit kp, bit cp, int hf);
    return 32'(lm1 & 31) | (32'(src) << 5) | (32'(fr) << 6) | (32'(kp) << 7)
         | (32'(cp) << 8) | (32'(hf & 127) << 9);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #0.5;
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(int lm1, bit src, bit fr, bit kp, bit cp, int hf);
    wr(2'd1, mk(lm1, src, fr, kp, cp, hf));
    mon_cpol = cp;
  endtask

  task automatic wait_frames(input string req, input int target);
    int t = 0;
    while (frames < target && t < 5000) begin @(negedge clk); #1; t++; end
    if (frames < target) check({req, " frame timeout"}, 64'(frames), 64'(target));
  endtask

  task automatic wait_cs_low(input string req);
    int t = 0;
    while (cs_n && t < 2000) begin @(negedge clk); #1; t++; end
    if (cs_n) check({req, " select timeout"}, 64'(cs_n), 64'd0);
  endtask

  task automatic count_sck(input int n, output int ch, output int hi);
    logic prev;
    ch = 0; hi = 0;
    @(negedge clk); #1; prev = sck;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (sck != prev) ch++;
      if (cs_n) hi++;
      prev = sck;
    end
  endtask

  task automatic measure_half(input int hf, input int exp);
    int f, c, t;
    logic prev;
    set_cfg(3, 0, 0, 0, 0, hf);
    wr(2'd0, 32'h5);
    f = frames;
    wr(2'd2, 0);
    wait_cs_low("R8");
    prev = sck; t = 0;
    while (sck == prev && t < 1000) begin @(negedge clk); #1; t++; end
    prev = sck; c = 0;
    while (sck == prev && c < 1000) begin @(negedge clk); #1; c++; end
    check($sformatf("R8 half period for field %0d", hf), 64'(c), 64'(exp));
    wait_frames("R8", f + 1);
  endtask

  localparam int NV = 6;
  localparam int T_LM1[NV]  = '{31, 7, 3, 0, 15, 20};
  localparam bit T_SRC[NV]  = '{0, 0, 1, 0, 1, 0};
  localparam bit T_FREE[NV] = '{0, 0, 0, 1, 1, 0};
  localparam bit T_CPOL[NV] = '{0, 1, 0, 0, 1, 0};
  localparam int T_HALF[NV] = '{1, 2, 1, 3, 0, 4};
  localparam logic [31:0] T_ALT[NV] = '{32'hA5C3_0F96, 32'h0000_01B4, 32'hFFFF_FFFF,
                                        32'h0000_0006, 32'h0000_0000, 32'h00F0_F0F0};
  localparam logic [31:0] T_PAR[NV] = '{32'h0, 32'h0, 32'h0000_000D,
                                        32'h0, 32'h1234_ABCD, 32'h0};

  task automatic run_table();
    for (int i = 0; i < NV; i++) begin
      int len, f, ch, hi;
      logic [63:0] msk, exp;
      len = (T_LM1[i] < 3) ? 4 : T_LM1[i] + 1;
      msk = (64'd1 << len) - 64'd1;
      exp = {32'd0, (T_SRC[i] ? T_PAR[i] : T_ALT[i])} & msk;
      set_cfg(T_LM1[i], T_SRC[i], T_FREE[i], 0, T_CPOL[i], T_HALF[i]);
      wr(2'd0, T_ALT[i]);
      par_in = T_PAR[i];
      f = frames;
      wr(2'd2, 0);
      wait_frames("R1", f + 1);
      check($sformatf("R1 R2 R3 row %0d word", i), last_word, exp);
      check($sformatf("R1 row %0d bit count", i), 64'(last_n), 64'(len));
      count_sck(12, ch, hi);
      if (T_FREE[i]) begin
        check($sformatf("R5 row %0d free clock toggles while idle", i), 64'(ch > 0), 64'd1);
      end else begin
        check($sformatf("R5 row %0d gated clock still while idle", i), 64'(ch), 64'd0);
        check($sformatf("R4 row %0d idle level", i), 64'(sck), 64'(T_CPOL[i]));
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int f, ch, hi, lo, t;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 cs_n after reset", 64'(cs_n), 64'd1);
    check("R10 sdo after reset", 64'(sdo), 64'd1);
    check("R10 sck after reset", 64'(sck), 64'd0);
    check("R10 frame_done after reset", 64'(frame_done), 64'd0);
    rst_n = 1'b1;

    // R10 default configuration: 32-bit frame from data word
    wr(2'd0, 32'h8000_0001);
    f = frames;
    wr(2'd2, 0);
    wait_frames("R10", f + 1);
    check("R10 default frame word", last_word, 64'h8000_0001);
    check("R10 default frame length", 64'(last_n), 64'd32);

    run_table();

    // R8 divider
    measure_half(5, 5);
    measure_half(0, 1);

    // R2 parallel bus sampled at frame start
    set_cfg(7, 1, 0, 0, 0, 4);
    par_in = 32'h0000_005A;
    f = frames;
    wr(2'd2, 0);
    wait_cs_low("R2");
    par_in = 32'h0000_00A5;
    wait_frames("R2", f + 1);
    check("R2 bus held from frame start", last_word, 64'h5A);

    // R6 R11 continuation, back-to-back, gated hold
    set_cfg(7, 0, 0, 1, 0, 1);
    wr(2'd0, 32'h81);
    f = frames;
    wr(2'd2, 0);
    wr(2'd2, 0);
    hi = 0; t = 0;
    while (frames < f + 2 && t < 2000) begin
      @(negedge clk); #1; t++;
      if (frames > f && frames < f + 2 && cs_n) hi++;
    end
    check("R11 two triggers give two frames", 64'(frames), 64'(f + 2));
    check("R6 select held between frames", 64'(hi), 64'd0);
    check("R6 second frame word", last_word, 64'h81);
    check("R6 second frame length", 64'(last_n), 64'd8);
    count_sck(10, ch, hi);
    check("R6 select held with nothing pending", 64'(hi), 64'd0);
    check("R5 gated clock still during hold", 64'(ch), 64'd0);
    check("R3 data high during hold", 64'(sdo), 64'd1);
    set_cfg(7, 0, 0, 0, 0, 1);
    repeat (10) @(negedge clk);
    #1;
    check("R6 select released after continuation cleared", 64'(cs_n), 64'd1);

    // R6 R3 free clock hold
    set_cfg(3, 0, 1, 1, 0, 1);
    wr(2'd0, 32'h9);
    f = frames;
    wr(2'd2, 0);
    wait_frames("R6", f + 1);
    check("R6 free hold frame word", last_word, 64'h9);
    ch = 0; hi = 0; lo = 0;
    begin
      logic prev;
      @(negedge clk); #1; prev = sck;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk); #1;
        if (sck != prev) ch++;
        if (cs_n) hi++;
        if (!sdo) lo++;
        prev = sck;
      end
    end
    check("R6 select held in free hold", 64'(hi), 64'd0);
    check("R3 data high in free hold", 64'(lo), 64'd0);
    check("R5 clock runs in free hold", 64'(ch > 0), 64'd1);
    set_cfg(3, 0, 1, 0, 0, 1);
    repeat (10) @(negedge clk);
    #1;
    check("R6 free hold released", 64'(cs_n), 64'd1);

    // R7 inter-frame gap
    set_cfg(3, 0, 0, 0, 0, 3);
    wr(2'd0, 32'hC);
    f = frames;
    wr(2'd2, 0);
    wait_cs_low("R7");
    wr(2'd2, 0);
    wait_frames("R7", f + 1);
    hi = 0; t = 0;
    while (cs_n && t < 2000) begin @(negedge clk); #1; t++; hi++; end
    check("R7 gap at least one clock period", 64'(hi >= 6), 64'd1);
    wait_frames("R7", f + 2);
    check("R7 second frame word", last_word, 64'hC);

    // R9 pulse shape
    check("R9 done never two cycles", 64'(dbl_done), 64'd0);
    check("R9 done only after select", 64'(done_unsel), 64'd0);

    finish_run();
  end
endmodule